// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point conditional branch, set or trap should take effect. It reads the four result flags left by the last floating-point operation (negative, zero, infinity, not-a-number) and a 6-bit predicate selector. From these it produces a one-bit condition result in the same cycle. The flags are reduced to four mutually exclusive relations: unordered, greater, less and equal. The low four selector bits pick which of these relations make the predicate true.

There are two families of predicates. Both families use the same truth tables. The ordered/unordered-aware family never raises an exception. The signalling family is chosen by selector bit 4. When a signalling predicate is evaluated while the not-a-number flag is set, the block raises a one-cycle registered strobe for the branch/set-on-unordered exception. The condition result is still delivered in that case. This is why "greater or less" is false on a NaN result while "not equal" is true. It is also why the negated ("N"-prefixed) signalling predicates come out true on a NaN result.

Top module: `fpcc_eval`

## Requirements
- R1: The flags input carries negative in bit 3, zero in bit 2, infinity in bit 1 and not-a-number in bit 0. The relations are: unordered = NAN; equal = Z and not NAN; less = N and not (NAN or Z); greater = not (NAN or Z or N).
- R2: `condTrue` is combinational. It is 1 when any relation enabled by `sel[3:0]` is true. The enables are: bit 3 unordered, bit 2 greater, bit 1 less, bit 0 equal. Examples: 0x0 never true, 0xF always true, 0x1 equal, 0xE not-equal, 0x6 greater-or-less, 0x7 ordered, 0x8 unordered, 0xD unordered-or-greater-or-equal.
- R3: `sel[4]` selects the signalling family. It does not change `condTrue`: a code with bit 4 set has the same truth table as the same code with bit 4 clear.
- R4: With the NAN flag set, greater-or-less (0x16 or 0x06) gives `condTrue`=0, while not-equal (0x0E or 0x1E) gives `condTrue`=1.
- R5: A negated predicate, whose code is the bitwise complement of its base code in `sel[3:0]` (for example not-greater-or-equal 0x1A against 0x15), always gives the inverse result. With NAN set it is true.
- R6: The infinity flag (bit 1) has no effect on `condTrue` or `bsunStrobe`.
- R7: `sel[5]` is spare and has no effect on `condTrue` or `bsunStrobe`.
- R8: When `evalValid`=1, `sel[4]`=1 and the NAN flag is 1 at a rising clock edge, `bsunStrobe` is 1 for the following cycle only, unless that edge also qualifies. Back-to-back qualifying evaluations give back-to-back strobe cycles.
- R9: `bsunStrobe` stays 0 after an edge where `evalValid`=0, or `sel[4]`=0, or the NAN flag is 0.
- R10: A strobe being raised does not suppress or alter `condTrue` for that evaluation or for the next one.
- R11: While `rstN` is low, `bsunStrobe` is 0, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the exception strobe register |
| rstN | input | 1 | Asynchronous active-low reset |
| evalValid | input | 1 | A predicate is being evaluated this cycle |
| sel | input | 6 | Predicate selector: relation enables [3:0], signalling family [4], spare [5] |
| flags | input | 4 | Result flags: N [3], Z [2], I [1], NAN [0] |
| condTrue | output | 1 | Combinational predicate result |
| bsunStrobe | output | 1 | Branch/set-on-unordered exception strobe, one cycle after the evaluation |

## Verification
The condition result of one evaluation and the exception strobe of the evaluation before it appear in the same cycle, because the strobe is registered. The bench provokes this overlap with back-to-back signalling evaluations on a NaN result, followed by a non-signalling one. In every cycle it samples both outputs. The result is judged against the truth table of the current selector, and the strobe against the family and flags of the previous cycle. This shows that neither output masks or delays the other.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  localparam int REL_CNT   = 4;
  localparam int FLAG_W    = 4;
  localparam int FLAG_NEG  = 3;
  localparam int FLAG_ZERO = 2;
  localparam int FLAG_INF  = 1;
  localparam int FLAG_NAN  = 0;

  // Strobes from control to datapath: which relations satisfy the predicate.
  typedef struct packed {
    logic pickUnord;
    logic pickGreater;
    logic pickLess;
    logic pickEqual;
  } relPick_t;

  // The four mutually exclusive comparison relations.
  typedef struct packed {
    logic unord;
    logic greater;
    logic less;
    logic equal;
  } relation_t;
endpackage

// File: rtl/fpcc_datapath.sv
module fpcc_datapath
  import fpcc_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  relPick_t          pick,
  output logic              condTrue
);
  relation_t          rel;
  logic [REL_CNT-1:0] hits;
  logic               unusedInf;

  // Reduce flags to exactly one active relation.
  always_comb begin
    rel.unord   = flags[FLAG_NAN];
    rel.equal   = flags[FLAG_ZERO] & ~flags[FLAG_NAN];
    rel.less    = flags[FLAG_NEG] & ~(flags[FLAG_NAN] | flags[FLAG_ZERO]);
    rel.greater = ~(flags[FLAG_NAN] | flags[FLAG_ZERO] | flags[FLAG_NEG]);
  end

  // Infinity only affects magnitude, never the ordering relation.
  assign unusedInf = flags[FLAG_INF];

  for (genvar i = 0; i < REL_CNT; i++) begin : g_hit
    assign hits[i] = rel[i] & pick[i];
  end

  assign condTrue = |hits;
endmodule

// File: rtl/fpcc_control.sv
module fpcc_control
  import fpcc_pkg::*;
#(
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evalValid,
  input  logic [SEL_W-1:0] sel,
  input  logic             flagNan,
  output relPick_t         pick,
  output logic             bsunStrobe
);
  localparam int FAMILY_BIT = REL_CNT;
  localparam int SPARE_LO   = FAMILY_BIT + 1;

  logic signalling;
  logic bsunNext;

  assign pick       = relPick_t'(sel[REL_CNT-1:0]);
  assign signalling = sel[FAMILY_BIT];

  if (SEL_W > SPARE_LO) begin : g_spare
    logic unusedSpare;
    assign unusedSpare = ^sel[SEL_W-1:SPARE_LO];
  end

  assign bsunNext = evalValid & signalling & flagNan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bsunStrobe <= 1'b0;
    else       bsunStrobe <= bsunNext;
  end
endmodule

// File: rtl/fpcc_eval.sv
module fpcc_eval
  import fpcc_pkg::*;
#(
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evalValid,
  input  logic [SEL_W-1:0] sel,
  input  logic [3:0]       flags,
  output logic             condTrue,
  output logic             bsunStrobe
);
  relPick_t pick;

  fpcc_control #(.SEL_W(SEL_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evalValid (evalValid),
    .sel       (sel),
    .flagNan   (flags[FLAG_NAN]),
    .pick      (pick),
    .bsunStrobe(bsunStrobe)
  );

  fpcc_datapath u_dp (
    .flags   (flags),
    .pick    (pick),
    .condTrue(condTrue)
  );
endmodule

// File: rtl/fpcc_eval_checker.sv
module fpcc_eval_checker #(
  parameter int SEL_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             evalValid,
  input logic [SEL_W-1:0] sel,
  input logic [3:0]       flags,
  input logic             condTrue,
  input logic             bsunStrobe
);
  assert_bsun_raise_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && sel[4] && flags[0]) |=> bsunStrobe);

  assert_bsun_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!evalValid || !sel[4] || !flags[0]) |=> !bsunStrobe);

  assert_gl_vs_ne_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && sel[3:0] == 4'b0110) |-> !condTrue);

  assert_nan_follows_unord_R5: assert property (@(posedge clk) disable iff (!rstN)
    flags[0] |-> (condTrue == sel[3]));

  assert_always_true_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sel[3:0] == 4'hF) |-> condTrue);

  always @(posedge clk) begin
    if (!rstN) assert_reset_clear_R11: assert (!bsunStrobe);
  end
endmodule

bind fpcc_eval fpcc_eval_checker #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/fpcc_eval_test.sv
module fpcc_eval_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evalValid = 1'b0;
  logic [5:0] sel = '0;
  logic [3:0] flags = '0;
  logic       condTrue;
  logic       bsunStrobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  fpcc_eval uut (
    .clk(clk), .rstN(rstN), .evalValid(evalValid), .sel(sel),
    .flags(flags), .condTrue(condTrue), .bsunStrobe(bsunStrobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s sel=%h flags=%b actual=%b expected=%b", req, sel, flags, act, exp);
    end
  endtask

  // Truth table written per predicate from the requirements (R1, R2).
  function automatic logic expCond(input logic [3:0] code, input logic [3:0] f);
    logic un, eq, gt, lt;
    un = f[0];
    eq = f[2] && !f[0];
    lt = f[3] && !f[0] && !f[2];
    gt = !f[0] && !f[2] && !f[3];
    case (code)
      4'h0: return 1'b0;
      4'h1: return eq;
      4'h2: return lt;
      4'h3: return lt || eq;
      4'h4: return gt;
      4'h5: return gt || eq;
      4'h6: return gt || lt;
      4'h7: return !un;
      4'h8: return un;
      4'h9: return un || eq;
      4'hA: return un || lt;
      4'hB: return !gt;
      4'hC: return un || gt;
      4'hD: return !lt;
      4'hE: return !eq;
      default: return 1'b1;
    endcase
  endfunction

  task automatic drive(input logic v, input logic [5:0] s, input logic [3:0] f);
    evalValid = v; sel = s; flags = f;
    #1;
  endtask

  task automatic testReset();
    // R11: signalling NaN evaluation while reset is held raises nothing.
    drive(1'b1, 6'h15, 4'b0001);
    @(negedge clk);
    check(bsunStrobe == 1'b0, "R11 reset", bsunStrobe, 1'b0);
    @(negedge clk);
    check(bsunStrobe == 1'b0, "R11 reset hold", bsunStrobe, 1'b0);
    drive(1'b0, 6'h00, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    check(bsunStrobe == 1'b0, "R11 after release", bsunStrobe, 1'b0);
  endtask

  // R1 R2 R3 R6 R7 R8 R9: every selector and flag pattern.
  task automatic testSweep();
    for (int sp = 0; sp < 2; sp++)
      for (int sg = 0; sg < 2; sg++)
        for (int c = 0; c < 16; c++)
          for (int f = 0; f < 16; f++) begin
            logic e, b;
            e = expCond(4'(c), 4'(f));
            b = (sg == 1) && (f[0] == 1'b1);
            drive(1'b1, {1'(sp), 1'(sg), 4'(c)}, 4'(f));
            check(condTrue == e, "R2 R3 R6 R7 cond", condTrue, e);
            @(negedge clk);
            check(bsunStrobe == b, "R8 R9 strobe", bsunStrobe, b);
          end
    drive(1'b0, 6'h00, 4'b0000);
    @(negedge clk);
  endtask

  task automatic testGlVsNe();
    drive(1'b1, 6'h16, 4'b0001);
    check(condTrue == 1'b0, "R4 GL on NaN", condTrue, 1'b0);
    drive(1'b1, 6'h0E, 4'b0001);
    check(condTrue == 1'b1, "R4 NE on NaN", condTrue, 1'b1);
    drive(1'b1, 6'h06, 4'b1001);
    check(condTrue == 1'b0, "R4 OGL on NaN", condTrue, 1'b0);
    drive(1'b0, 6'h00, 4'b0000);
    @(negedge clk);
  endtask

  task automatic testNegation();
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        logic base;
        drive(1'b0, {2'b01, 4'(c)}, 4'(f));
        base = condTrue;
        drive(1'b0, {2'b01, ~4'(c)}, 4'(f));
        check(condTrue == !base, "R5 negation", condTrue, !base);
      end
    drive(1'b0, 6'h1A, 4'b0001);
    check(condTrue == 1'b1, "R5 NGE on NaN", condTrue, 1'b1);
    drive(1'b0, 6'h00, 4'b0000);
    @(negedge clk);
  endtask

  task automatic testInfIgnored();
    drive(1'b1, 6'h14, 4'b0010);
    check(condTrue == 1'b1, "R6 +inf greater", condTrue, 1'b1);
    drive(1'b1, 6'h12, 4'b1010);
    check(condTrue == 1'b1, "R6 -inf less", condTrue, 1'b1);
    @(negedge clk);
    check(bsunStrobe == 1'b0, "R6 no strobe", bsunStrobe, 1'b0);
    drive(1'b0, 6'h00, 4'b0000);
    @(negedge clk);
  endtask

  task automatic testNoEval();
    drive(1'b0, 6'h3F, 4'b0001);
    check(condTrue == 1'b1, "R10 cond w/o eval", condTrue, 1'b1);
    @(negedge clk);
    check(bsunStrobe == 1'b0, "R9 no eval", bsunStrobe, 1'b0);
  endtask

  task automatic testBackToBack();
    drive(1'b1, 6'h15, 4'b0001);          // GE on NaN: false, strobe
    check(condTrue == 1'b0, "R10 GE NaN", condTrue, 1'b0);
    @(negedge clk);
    check(bsunStrobe == 1'b1, "R8 first strobe", bsunStrobe, 1'b1);
    drive(1'b1, 6'h3A, 4'b0001);          // NGE on NaN, spare set: true, strobe
    check(condTrue == 1'b1, "R10 NGE NaN with strobe", condTrue, 1'b1);
    check(bsunStrobe == 1'b1, "R8 strobe held from previous", bsunStrobe, 1'b1);
    @(negedge clk);
    check(bsunStrobe == 1'b1, "R8 second strobe", bsunStrobe, 1'b1);
    drive(1'b1, 6'h0E, 4'b0001);          // NE non-signalling
    check(condTrue == 1'b1, "R10 NE during strobe", condTrue, 1'b1);
    @(negedge clk);
    check(bsunStrobe == 1'b0, "R9 non-signalling", bsunStrobe, 1'b0);
    drive(1'b1, 6'h15, 4'b0100);          // signalling, no NaN
    check(condTrue == 1'b1, "R2 GE on zero", condTrue, 1'b1);
    @(negedge clk);
    check(bsunStrobe == 1'b0, "R9 ordered", bsunStrobe, 1'b0);
    drive(1'b0, 6'h00, 4'b0000);
    @(negedge clk);
    check(bsunStrobe == 1'b0, "R8 single cycle", bsunStrobe, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%b expected=%b", 1'b0, 1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testSweep();
    testGlVsNe();
    testNegation();
    testInfIgnored();
    testNoEval();
    testBackToBack();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule